// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This block is a small processor core that completes one instruction on every enabled clock. The instruction set is a compact 32-bit RISC subset: register add, subtract, and, or and set-less-than; add-immediate; load word; store word; branch-if-equal; and jump. The core holds the program counter, a 32-entry register file with two combinational read ports and one clocked write port, a main decoder, an ALU control decoder, the sign extender, and all datapath selectors. Instruction and data memories are word arrays inside the core.

A test environment or boot agent fills both memories through a load port while the core is idle. It then raises `run` to let the core execute. Each cycle the core presents its program counter, the register write it is about to commit and any data-memory store it is about to perform. The surrounding logic can therefore follow architectural state without reaching into the core.

Top module: `rc_core`

## Requirements
- R1: While `rst_n` is low, and until `run` is high after reset release, `pc_o` is 0 and no register or memory write is committed.
- R2: An instruction that is neither a taken branch nor a jump advances `pc_o` by 4 on the enabled edge.
- R3: Opcode 0 selects a register operation by the function field in bits 5:0. 0x20 is add, 0x22 is subtract, 0x24 is and, 0x25 is or, and 0x2A is set-less-than. Set-less-than yields 1 exactly when bit 31 of rs−rt is 1, else 0.
- R4: The destination register is bits 15:11 for register operations and bits 20:16 for add-immediate and load. Sources are bits 25:21 (rs) and 20:16 (rt).
- R5: Opcode 0x08 writes rs plus the sign-extended bits 15:0 to the destination register.
- R6: Opcode 0x2B stores rt to the data word at rs plus the sign-extended offset, and writes no register. Opcode 0x23 writes the data word at that address to the destination register. The word index is address bits 7:2 at the default depth.
- R7: Opcode 0x04 with rs equal to rt sets the next PC to PC+4 plus the sign-extended offset shifted left by 2. Otherwise the next PC is PC+4.
- R8: Opcode 0x02 sets the next PC to bits 31:28 of PC+4, followed by instruction bits 25:0, followed by two zero bits.
- R9: Register 0 reads as zero, and a write addressed to it is dropped, so `rf_we_o` stays low.
- R10: While `run` is low, the PC holds and no register or data store is committed.
- R11: Any other opcode, or an opcode-0 function outside R3, commits nothing and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Execution enable |
| load_we | input | 1 | Load-port write strobe |
| load_to_data | input | 1 | Load target: 0 instruction memory, 1 data memory |
| load_addr | input | LA_W | Load word index |
| load_data | input | 32 | Load word |
| pc_o | output | 32 | Current program counter |
| rf_we_o | output | 1 | Register write committed this cycle |
| rf_waddr_o | output | 5 | Register write index |
| rf_wdata_o | output | 32 | Register write value |
| dm_we_o | output | 1 | Data store committed this cycle |
| dm_addr_o | output | 32 | Data byte address |
| dm_wdata_o | output | 32 | Store value |

## Verification
The assertions assume that the load port is used only while `run` is low. They also assume that programs keep instruction and data addresses word-aligned and inside the two arrays, so the index truncation never aliases. The stimulus meets these assumptions. Every load happens during reset, and the generated programs compute only aligned data addresses within the data array. Branch and jump offsets in the programs are chosen so that every target falls inside the loaded code.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_JMP  = 6'h02;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_LDW  = 6'h23;
  localparam logic [5:0] OPC_STW  = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  // bit 2 inverts operand b and carries in; bits 1:0 pick the result
  typedef enum logic [2:0] {
    ALU_AND  = 3'b000,
    ALU_OR   = 3'b001,
    ALU_ADD  = 3'b010,
    ALU_ANDN = 3'b100,
    ALU_ORN  = 3'b101,
    ALU_SUB  = 3'b110,
    ALU_SLT  = 3'b111
  } alu_fn_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10
  } alu_op_e;

  typedef struct packed {
    logic    reg_write;
    logic    reg_dst;
    logic    alu_src;
    logic    mem_to_reg;
    logic    mem_write;
    logic    branch;
    logic    jump;
    alu_fn_e alu_fn;
  } ctrl_t;
endpackage

// File: rtl/rc_decoder.sv
module rc_decoder
  import rc_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  alu_op_e aop;
  logic    main_wr;
  logic    fn_ok;
  alu_fn_e fn_sel;

  // main decoder
  always_comb begin
    ctrl.reg_dst    = 1'b0;
    ctrl.alu_src    = 1'b0;
    ctrl.mem_to_reg = 1'b0;
    ctrl.mem_write  = 1'b0;
    ctrl.branch     = 1'b0;
    ctrl.jump       = 1'b0;
    main_wr         = 1'b0;
    aop             = AOP_ADD;
    case (opcode)
      OPC_REG:  begin main_wr = 1'b1; ctrl.reg_dst = 1'b1; aop = AOP_FUNCT; end
      OPC_ADDI: begin main_wr = 1'b1; ctrl.alu_src = 1'b1; end
      OPC_LDW:  begin main_wr = 1'b1; ctrl.alu_src = 1'b1; ctrl.mem_to_reg = 1'b1; end
      OPC_STW:  begin ctrl.alu_src = 1'b1; ctrl.mem_write = 1'b1; end
      OPC_BEQ:  begin ctrl.branch = 1'b1; aop = AOP_SUB; end
      OPC_JMP:  begin ctrl.jump = 1'b1; end
      default:  ;
    endcase
  end

  // ALU control decoder
  always_comb begin
    fn_ok  = 1'b1;
    fn_sel = ALU_ADD;
    case (aop)
      AOP_SUB: fn_sel = ALU_SUB;
      AOP_FUNCT: begin
        case (funct)
          FN_ADD:  fn_sel = ALU_ADD;
          FN_SUB:  fn_sel = ALU_SUB;
          FN_AND:  fn_sel = ALU_AND;
          FN_OR:   fn_sel = ALU_OR;
          FN_SLT:  fn_sel = ALU_SLT;
          default: fn_ok = 1'b0;
        endcase
      end
      default: fn_sel = ALU_ADD;
    endcase
  end

  assign ctrl.alu_fn    = fn_sel;
  assign ctrl.reg_write = main_wr & fn_ok;
endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import rc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  logic [W-1:0] b_eff;
  logic [W-1:0] sum;

  assign b_eff = fn[2] ? ~b : b;
  assign sum   = a + b_eff + {{(W-1){1'b0}}, fn[2]};

  always_comb begin
    case (fn[1:0])
      2'b00:   y = a & b_eff;
      2'b01:   y = a | b_eff;
      2'b10:   y = sum;
      default: y = {{(W-1){1'b0}}, sum[W-1]};
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/rc_regfile.sv
module rc_regfile #(
  parameter int W     = 32,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [W-1:0]  rd1,
  output logic [W-1:0]  rd2
);
  logic [W-1:0] regs [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (wa != '0)) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/rc_wordmem.sv
module rc_wordmem #(
  parameter int W     = 32,
  parameter int WORDS = 64,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rc_core.sv
module rc_core
  import rc_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  localparam int IA_W = $clog2(IMEM_WORDS),
  localparam int DA_W = $clog2(DMEM_WORDS),
  localparam int LA_W = (IA_W > DA_W) ? IA_W : DA_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            load_we,
  input  logic            load_to_data,
  input  logic [LA_W-1:0] load_addr,
  input  logic [31:0]     load_data,
  output logic [31:0]     pc_o,
  output logic            rf_we_o,
  output logic [4:0]      rf_waddr_o,
  output logic [31:0]     rf_wdata_o,
  output logic            dm_we_o,
  output logic [31:0]     dm_addr_o,
  output logic [31:0]     dm_wdata_o
);
  localparam int XLEN = 32;
  localparam int NREG = 32;

  logic [1:0]      rst_q;
  logic            ready;
  logic            adv;
  logic [XLEN-1:0] pc_q, pc_d, pc4, br_tgt, jmp_tgt;
  logic [XLEN-1:0] instr, imm_ext, rd1, rd2, alu_b, alu_y, dm_rdata, wb_data;
  logic [4:0]      wa;
  logic            zero, take_br, rf_we;
  logic            dm_we;
  logic [DA_W-1:0] dm_waddr;
  logic [XLEN-1:0] dm_wdata;
  ctrl_t           ctrl;

  // reset release synchroniser
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign ready = rst_q[1];
  assign adv   = run & ready;

  // program counter: next state
  assign pc4     = pc_q + 32'd4;
  assign imm_ext = {{16{instr[15]}}, instr[15:0]};
  assign br_tgt  = pc4 + {imm_ext[29:0], 2'b00};
  assign jmp_tgt = {pc4[31:28], instr[25:0], 2'b00};
  assign take_br = ctrl.branch & zero;

  always_comb begin
    if (ctrl.jump)   pc_d = jmp_tgt;
    else if (take_br) pc_d = br_tgt;
    else             pc_d = pc4;
  end

  // program counter: register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pc_q <= '0;
    else if (adv) pc_q <= pc_d;
  end

  rc_wordmem #(.W(XLEN), .WORDS(IMEM_WORDS)) u_imem (
    .clk   (clk),
    .we    (load_we & ~load_to_data),
    .waddr (load_addr[IA_W-1:0]),
    .wdata (load_data),
    .raddr (pc_q[IA_W+1:2]),
    .rdata (instr)
  );

  rc_decoder u_dec (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctrl   (ctrl)
  );

  assign wa    = ctrl.reg_dst ? instr[15:11] : instr[20:16];
  assign rf_we = ctrl.reg_write & adv;

  rc_regfile #(.W(XLEN), .DEPTH(NREG)) u_rf (
    .clk (clk),
    .we  (rf_we),
    .wa  (wa),
    .wd  (wb_data),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .rd1 (rd1),
    .rd2 (rd2)
  );

  assign alu_b = ctrl.alu_src ? imm_ext : rd2;

  rc_alu #(.W(XLEN)) u_alu (
    .a    (rd1),
    .b    (alu_b),
    .fn   (ctrl.alu_fn),
    .y    (alu_y),
    .zero (zero)
  );

  // data memory write port shared between loader and core stores
  always_comb begin
    if (load_we && load_to_data) begin
      dm_we    = 1'b1;
      dm_waddr = load_addr[DA_W-1:0];
      dm_wdata = load_data;
    end else begin
      dm_we    = ctrl.mem_write & adv;
      dm_waddr = alu_y[DA_W+1:2];
      dm_wdata = rd2;
    end
  end

  rc_wordmem #(.W(XLEN), .WORDS(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .we    (dm_we),
    .waddr (dm_waddr),
    .wdata (dm_wdata),
    .raddr (alu_y[DA_W+1:2]),
    .rdata (dm_rdata)
  );

  assign wb_data = ctrl.mem_to_reg ? dm_rdata : alu_y;

  assign pc_o       = pc_q;
  assign rf_we_o    = rf_we & (wa != 5'd0);
  assign rf_waddr_o = wa;
  assign rf_wdata_o = wb_data;
  assign dm_we_o    = ctrl.mem_write & adv;
  assign dm_addr_o  = alu_y;
  assign dm_wdata_o = rd2;
endmodule

// File: rtl/rc_core_chk.sv
module rc_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        adv,
  input logic        jump,
  input logic        branch,
  input logic [31:0] pc_o,
  input logic [31:0] instr,
  input logic        rf_we_o,
  input logic [4:0]  rf_waddr_o,
  input logic        dm_we_o
);
  logic [31:0] pc_plus;
  assign pc_plus = pc_o + 32'd4;

  p_pc_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_o[1:0] == 2'b00);

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !jump && !branch) |=> (pc_o == $past(pc_plus)));

  p_jump_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && jump) |=> (pc_o == {$past(pc_plus[31:28]), $past(instr[25:0]), 2'b00}));

  p_hold_pc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(pc_o));

  p_idle_nowrite_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |-> (!rf_we_o && !dm_we_o));

  p_zero_dest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we_o |-> (rf_waddr_o != 5'd0));

  p_store_nowb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we_o |-> !rf_we_o);
endmodule

bind rc_core rc_core_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .adv        (adv),
  .jump       (ctrl.jump),
  .branch     (ctrl.branch),
  .pc_o       (pc_o),
  .instr      (instr),
  .rf_we_o    (rf_we_o),
  .rf_waddr_o (rf_waddr_o),
  .dm_we_o    (dm_we_o)
);

// File: tb/rc_core_test.sv
module rc_core_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        load_we = 1'b0;
  logic        load_to_data = 1'b0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc_o, rf_wdata_o, dm_addr_o, dm_wdata_o;
  logic        rf_we_o, dm_we_o;
  logic [4:0]  rf_waddr_o;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 0;

  logic [31:0] imem_m [64];
  logic [31:0] dmem_m [64];
  logic [31:0] regs_m [32];
  logic [31:0] pc_m;

  always #5 clk = ~clk;

  rc_core uut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .load_we(load_we), .load_to_data(load_to_data),
    .load_addr(load_addr), .load_data(load_data),
    .pc_o(pc_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
    .rf_wdata_o(rf_wdata_o), .dm_we_o(dm_we_o),
    .dm_addr_o(dm_addr_o), .dm_wdata_o(dm_wdata_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic build(input logic [15:0] va, input logic [15:0] vb, input logic [15:0] vc);
    for (int i = 0; i < 64; i++) imem_m[i] = 32'h0;
    imem_m[0]  = enc_i(6'h08, 0, 1, va);
    imem_m[1]  = enc_i(6'h08, 0, 2, vb);
    imem_m[2]  = enc_i(6'h08, 0, 3, vc);
    imem_m[3]  = enc_r(1, 2, 4, 6'h20);
    imem_m[4]  = enc_r(2, 1, 5, 6'h22);
    imem_m[5]  = enc_r(1, 3, 6, 6'h24);
    imem_m[6]  = enc_r(2, 1, 7, 6'h25);
    imem_m[7]  = enc_r(2, 1, 8, 6'h2A);
    imem_m[8]  = enc_r(1, 2, 9, 6'h2A);
    imem_m[9]  = enc_i(6'h08, 1, 0, 16'd9);
    imem_m[10] = enc_r(0, 1, 10, 6'h20);
    imem_m[11] = enc_i(6'h08, 0, 11, 16'd40);
    imem_m[12] = enc_i(6'h2B, 11, 5, 16'hFFFC);
    imem_m[13] = enc_i(6'h23, 11, 12, 16'hFFFC);
    imem_m[14] = enc_i(6'h04, 1, 10, 16'd2);
    imem_m[15] = enc_i(6'h08, 0, 13, 16'd1);
    imem_m[16] = enc_i(6'h08, 0, 13, 16'd2);
    imem_m[17] = enc_i(6'h04, 1, 2, 16'd5);
    imem_m[18] = 32'hFC00_0000;
    imem_m[19] = {6'h02, 26'd22};
    imem_m[20] = enc_i(6'h08, 0, 14, 16'd3);
    imem_m[21] = enc_r(1, 1, 14, 6'h27);
    imem_m[22] = enc_r(12, 3, 15, 6'h20);
    imem_m[23] = enc_i(6'h04, 0, 0, 16'hFFFF);
  endtask

  task automatic load_all();
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      load_we = 1'b1; load_to_data = 1'b0; load_addr = 6'(i); load_data = imem_m[i];
      @(negedge clk);
      dmem_m[i] = 32'(i * 3 + 1);
      load_to_data = 1'b1; load_data = dmem_m[i];
    end
    @(negedge clk);
    load_we = 1'b0; load_to_data = 1'b0;
  endtask

  task automatic step();
    logic [31:0] ins, a, b, imm, npc, wd, da, dwd, p4;
    logic [4:0]  rs, rt, rd, wa;
    logic        we, dwe;
    string       tag;
    ins = imem_m[pc_m[7:2]];
    rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
    a = (rs == 0) ? 32'h0 : regs_m[rs];
    b = (rt == 0) ? 32'h0 : regs_m[rt];
    imm = {{16{ins[15]}}, ins[15:0]};
    p4 = pc_m + 32'd4;
    npc = p4; we = 0; wa = 0; wd = 0; dwe = 0; da = 0; dwd = 0; tag = "R2";
    case (ins[31:26])
      6'h00: begin
        we = 1; wa = rd; tag = "R3";
        case (ins[5:0])
          6'h20: wd = a + b;
          6'h22: wd = a - b;
          6'h24: wd = a & b;
          6'h25: wd = a | b;
          6'h2A: wd = {31'd0, 1'((a - b) >> 31)};
          default: begin we = 0; tag = "R11"; end
        endcase
      end
      6'h08: begin we = 1; wa = rt; wd = a + imm; tag = "R5"; end
      6'h23: begin we = 1; wa = rt; da = a + imm; wd = dmem_m[da[7:2]]; tag = "R6"; end
      6'h2B: begin dwe = 1; da = a + imm; dwd = b; tag = "R6"; end
      6'h04: begin tag = "R7"; if (a == b) npc = p4 + (imm << 2); end
      6'h02: begin tag = "R8"; npc = {p4[31:28], ins[25:0], 2'b00}; end
      default: tag = "R11";
    endcase
    if (we && wa == 0) begin we = 0; tag = "R9"; end
    #1;
    check(pc_o == pc_m, tag, "pc", pc_o, pc_m);
    check(rf_we_o == we, tag, "reg write strobe", 32'(rf_we_o), 32'(we));
    if (we) begin
      check(rf_waddr_o == wa, "R4", "dest index", 32'(rf_waddr_o), 32'(wa));
      check(rf_wdata_o == wd, tag, "write value", rf_wdata_o, wd);
    end
    check(dm_we_o == dwe, tag, "store strobe", 32'(dm_we_o), 32'(dwe));
    if (dwe) begin
      check(dm_addr_o == da, "R6", "store address", dm_addr_o, da);
      check(dm_wdata_o == dwd, "R6", "store value", dm_wdata_o, dwd);
    end
    if (we) regs_m[wa] = wd;
    if (dwe) dmem_m[da[7:2]] = dwd;
    pc_m = npc;
  endtask

  task automatic one_pass(input logic [15:0] va, input logic [15:0] vb, input logic [15:0] vc);
    run = 1'b0;
    rst_n = 1'b0;
    build(va, vb, vc);
    load_all();
    #1;
    check(pc_o == 32'h0, "R1", "pc in reset", pc_o, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) @(negedge clk);
    #1;
    check(pc_o == 32'h0, "R1", "pc before run", pc_o, 32'h0);
    check(!rf_we_o && !dm_we_o, "R1", "writes before run", 32'({rf_we_o, dm_we_o}), 32'h0);
    pc_m = 32'h0;
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      if (s == 6) begin
        run = 1'b0;
        #1;
        check(!rf_we_o && !dm_we_o, "R10", "writes while paused", 32'({rf_we_o, dm_we_o}), 32'h0);
        @(negedge clk);
        #1;
        check(pc_o == pc_m, "R10", "pc held", pc_o, pc_m);
        @(negedge clk);
      end
      run = 1'b1;
      step();
    end
    @(negedge clk);
    run = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) regs_m[i] = 32'h0;
    pc_m = 32'h0;
    one_pass(16'd5, 16'hFFFD, 16'h7FFF);
    one_pass(16'hFFFF, 16'd1, 16'h8000);
    one_pass(16'd7, 16'd7, 16'h0000);
    one_pass(16'h1234, 16'hF00F, 16'h00FF);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule